// File: doc/BRIEF.md
# Codec Serial Command Bridge

This block sits between a byte-wide host register port and the control interface of an external audio converter. It has two command targets. One is the converter's output stage, which takes 16-bit commands: a register-select byte followed by a value byte. The other is an input-gain stage, which takes 32-bit words. The host frames each transaction with read strobes and never writes a length or a start bit. A read at one offset opens the output-converter select, a read at another opens the input-gain select, and a read at a third offset closes whichever select is open.

Between the opening and closing reads, the host writes one byte per serial bit to the data offset. Only bit 7 of each byte matters, and it becomes the serial data for one clock pulse. The host software decides the bit order. Commands go most significant bit first. A gain word is laid out, from the first bit sent, as mic level, mic level again, right line level and left line level, each 8 bits wide.

The pulse timing comes from a half-period divider. A one-deep holding register lets the host post a bit while the previous one is still on the wire. A busy flag tells the host when the wire is idle, and a sticky error flag records writes that were lost.

Top module: `codec_cmd_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, both selects, `ser_clk`, `ser_dat`, `busy` and `err` are 0 after that edge.
- R2: When neither select is high, a read strobe at offset 0x38 raises `sel_conv` after the sampling edge. A read strobe at offset 0x2C raises `sel_gain` instead. At most one select is high at any time.
- R3: An opening read (0x38 or 0x2C) made while a select is already high changes neither select.
- R4: A read strobe at offset 0x28 while a select is high requests release. The select falls on the first edge at which the bit engine is idle (`busy` low at that edge) and no data bit is being accepted. It never falls while `busy` is high.
- R5: Each accepted write to offset 0x2C produces exactly one `ser_clk` pulse carrying `host_wdata[7]` on `ser_dat`. `ser_dat` changes only while `ser_clk` is low. It is settled at least HALF_DIV cycles before the rising edge, and `ser_clk` stays high for exactly HALF_DIV cycles. `ser_clk` is high only while a select is high.
- R6: Bits leave in the order they were written. A 16-bit converter command such as 0xA65A (register byte 0xA6, value 0x5A) and a 32-bit gain word {mic, mic, right, left} appear bit for bit on the wire.
- R7: `busy` is high from the edge after an accepted write until the last pulse's high phase has ended with no bit held. `busy` is high whenever `ser_clk` is high.
- R8: A bit written while the engine is shifting is held (one entry) and sent right after the current bit, with no idle gap. A bit written while the holding entry is full is discarded and sets `err`. A write arriving in the final cycle of a pulse chains straight on.
- R9: A data write made with no select high produces no pulse and sets `err`. `err` stays set until an opening read is accepted, which clears it.
- R10: Writes to any offset other than 0x2C, and reads of any offset other than 0x38, 0x2C and 0x28, change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 8 | Register offset of the current host access |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 8 | Write byte; bit 7 is the serial bit value |
| sel_conv | output | 1 | Select for the output-converter command port, active high |
| sel_gain | output | 1 | Select for the input-gain port, active high |
| ser_clk | output | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | output | 1 | Serial data |
| busy | output | 1 | A bit is on the wire or held |
| err | output | 1 | Sticky flag: a write was lost |

## Verification
The bench builds the block with HALF_DIV = 3 and the default offsets. An odd, multi-cycle half period makes setup and high-phase widths distinguishable from off-by-one counters. A six-cycle bit period lets writes spaced exactly one period apart land on the final cycle of a pulse, which exercises direct chaining. Writes on three consecutive cycles fill the holding entry and reach the discard path while the first bit is still in its setup phase.

// File: rtl/ccb_pkg.sv
// Shared types for the codec serial command bridge.
package ccb_pkg;

    // Phase of the single-bit serial engine.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HIGH  = 2'd2
    } ccb_phase_e;

endpackage

// File: rtl/ccb_host_decode.sv
// Host register decode.
// Turns one-cycle read and write strobes at fixed offsets into
// command pulses for the select controller. Purely combinational.
// Assumes the host holds address and data valid with the strobe.
module ccb_host_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_CONV = 8'h38,
    parameter logic [ADDR_W-1:0] OFS_GAIN = 8'h2C,
    parameter logic [ADDR_W-1:0] OFS_CLOSE = 8'h28
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic              open_conv,
    output logic              open_gain,
    output logic              close_rd,
    output logic              bit_wr,
    output logic              bit_val
);
    logic unused_low;

    // Offset compare for every strobe kind.
    always_comb begin
        open_conv  = host_rd && (host_addr == OFS_CONV);
        open_gain  = host_rd && (host_addr == OFS_GAIN);
        close_rd   = host_rd && (host_addr == OFS_CLOSE);
        bit_wr     = host_wr && (host_addr == OFS_GAIN);
        bit_val    = host_wdata[7];
        unused_low = ^host_wdata[6:0];
    end
endmodule

// File: rtl/ccb_select_ctrl.sv
// Select controller.
// Holds the two target selects, the deferred close request and the
// sticky error flag. Gates data writes so that only writes made with a
// select high reach the bit engine. Assumes the engine's busy output
// covers both the bit on the wire and the holding entry.
module ccb_select_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic open_conv,
    input  logic open_gain,
    input  logic close_rd,
    input  logic bit_wr,
    input  logic eng_busy,
    input  logic eng_drop,
    output logic sel_conv,
    output logic sel_gain,
    output logic err,
    output logic bit_go
);
    logic close_pend;
    logic any_sel;

    // A data bit is accepted only inside an open transaction.
    always_comb begin
        any_sel = sel_conv || sel_gain;
        bit_go  = bit_wr && any_sel;
    end

    // Open a select when none is open; release it once the engine drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_conv   <= 1'b0;
            sel_gain   <= 1'b0;
            close_pend <= 1'b0;
        end else if (!any_sel) begin
            if (open_conv)
                sel_conv <= 1'b1;
            else if (open_gain)
                sel_gain <= 1'b1;
        end else if (close_pend && !eng_busy && !bit_go) begin
            sel_conv   <= 1'b0;
            sel_gain   <= 1'b0;
            close_pend <= 1'b0;
        end else if (close_rd) begin
            close_pend <= 1'b1;
        end
    end

    // Sticky error: set on a lost write, cleared by an accepted open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (!any_sel && (open_conv || open_gain))
            err <= 1'b0;
        else if ((bit_wr && !any_sel) || eng_drop)
            err <= 1'b1;
    end
endmodule

// File: rtl/ccb_bit_engine.sv
// Single-bit serial engine with a one-deep holding entry.
// Each accepted bit drives ser_dat with ser_clk low for HALF_DIV cycles,
// then ser_clk high for HALF_DIV cycles. A held bit, or a bit arriving
// in the last high cycle, starts on the same edge the pulse ends.
// Assumes HALF_DIV >= 1.
module ccb_bit_engine
    import ccb_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_go,
    input  logic bit_val,
    output logic ser_clk,
    output logic ser_dat,
    output logic busy,
    output logic drop
);
    localparam int              CW   = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0]   LAST = CW'(HALF_DIV - 1);

    ccb_phase_e    phase;
    logic [CW-1:0] cnt;
    logic          hold_v;
    logic          hold_b;
    logic          half_done;
    logic          slot_free;

    // Slot is free when idle or in the final high cycle of a pulse.
    always_comb begin
        half_done = (cnt == LAST);
        slot_free = (phase == PH_IDLE) || ((phase == PH_HIGH) && half_done);
        drop      = bit_go && !slot_free && hold_v;
        busy      = (phase != PH_IDLE) || hold_v;
    end

    // Phase sequencing, divider count, wire outputs and holding entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            ser_clk <= 1'b0;
            ser_dat <= 1'b0;
            hold_v  <= 1'b0;
            hold_b  <= 1'b0;
        end else if (slot_free) begin
            cnt     <= '0;
            ser_clk <= 1'b0;
            if (hold_v || bit_go) begin
                phase   <= PH_SETUP;
                ser_dat <= hold_v ? hold_b : bit_val;
            end else begin
                phase   <= PH_IDLE;
            end
            hold_v <= hold_v && bit_go;
            if (hold_v && bit_go)
                hold_b <= bit_val;
        end else begin
            if (half_done) begin
                phase   <= PH_HIGH;
                ser_clk <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (bit_go && !hold_v) begin
                hold_v <= 1'b1;
                hold_b <= bit_val;
            end
        end
    end
endmodule

// File: rtl/codec_cmd_bridge.sv
// Codec serial command bridge, top level.
// Byte-wide host register port in; two selects plus a shared serial
// clock and data line out. Read strobes frame transactions, and every
// data write carries one serial bit in bit 7.
module codec_cmd_bridge #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] OFS_CONV  = 8'h38,
    parameter logic [ADDR_W-1:0] OFS_GAIN  = 8'h2C,
    parameter logic [ADDR_W-1:0] OFS_CLOSE = 8'h28,
    parameter int                HALF_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic              sel_conv,
    output logic              sel_gain,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              busy,
    output logic              err
);
    logic open_conv, open_gain, close_rd, bit_wr, bit_val;
    logic bit_go, eng_drop;

    ccb_host_decode #(
        .ADDR_W(ADDR_W), .OFS_CONV(OFS_CONV),
        .OFS_GAIN(OFS_GAIN), .OFS_CLOSE(OFS_CLOSE)
    ) u_dec (
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_wdata(host_wdata),
        .open_conv (open_conv),
        .open_gain (open_gain),
        .close_rd  (close_rd),
        .bit_wr    (bit_wr),
        .bit_val   (bit_val)
    );

    ccb_select_ctrl u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_conv(open_conv),
        .open_gain(open_gain),
        .close_rd (close_rd),
        .bit_wr   (bit_wr),
        .eng_busy (busy),
        .eng_drop (eng_drop),
        .sel_conv (sel_conv),
        .sel_gain (sel_gain),
        .err      (err),
        .bit_go   (bit_go)
    );

    ccb_bit_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_go (bit_go),
        .bit_val(bit_val),
        .ser_clk(ser_clk),
        .ser_dat(ser_dat),
        .busy   (busy),
        .drop   (eng_drop)
    );
endmodule

// File: rtl/ccb_checker.sv
// Protocol checker for codec_cmd_bridge, attached by bind.
// Observes the ports only.
module ccb_checker (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic sel_conv,
    input logic sel_gain,
    input logic ser_clk,
    input logic ser_dat,
    input logic busy,
    input logic err
);
    // R2: never two selects at once
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_conv, sel_gain}));

    // R4: a select falls only after an idle cycle
    a_r4_conv_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_conv) |-> !$past(busy));

    a_r4_gain_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_gain) |-> !$past(busy));

    // R5: clock pulses only inside a transaction
    a_r5_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (sel_conv || sel_gain));

    // R5: data held while clock stays high
    a_r5_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

    // R5: data already settled when clock rises
    a_r5_data_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));

    // R7: busy covers every pulse
    a_r7_busy_when_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> busy);

    // R9: error only raised by a host write
    a_r9_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(host_wr));
endmodule

bind codec_cmd_bridge ccb_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_wr (host_wr),
    .sel_conv(sel_conv),
    .sel_gain(sel_gain),
    .ser_clk (ser_clk),
    .ser_dat (ser_dat),
    .busy    (busy),
    .err     (err)
);

// File: tb/sim_codec_cmd_bridge.sv
`timescale 1ns/1ps
// Bench for codec_cmd_bridge: behavioural model of selects and error
// compared every clock, plus serial frame capture and timing checks.
module sim_codec_cmd_bridge;
    localparam int HD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       sel_conv, sel_gain, ser_clk, ser_dat, busy, err;

    int n_chk = 0;
    int n_err = 0;

    // model state
    bit m_conv = 0, m_gain = 0, m_err = 0, m_pend = 0, m_rel_due = 0;

    // monitor state
    bit cap[$];
    int cyc = 0, last_chg = 0, hi_cnt = 0;
    bit prev_clk = 0, prev_dat = 0;

    always #2.5 clk = ~clk;

    codec_cmd_bridge #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .sel_conv(sel_conv),
        .sel_gain(sel_gain), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .busy(busy), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Per-clock model comparison and serial monitor.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (m_rel_due) begin
                m_conv = 0; m_gain = 0; m_pend = 0; m_rel_due = 0;
            end
            chk(sel_conv == m_conv, "R2/R4 sel_conv", sel_conv, m_conv);
            chk(sel_gain == m_gain, "R2/R4 sel_gain", sel_gain, m_gain);
            chk(err == m_err, "R9 err", err, m_err);
            if (m_pend && !busy) m_rel_due = 1;
            if (ser_dat != prev_dat) begin
                if (ser_clk && prev_clk) chk(0, "R5 data moved while high", 1, 0);
                last_chg = cyc;
            end
            if (ser_clk) begin
                chk(busy, "R7 busy during pulse", busy, 1);
                hi_cnt++;
            end
            if (ser_clk && !prev_clk) begin
                cap.push_back(ser_dat);
                chk(cyc - last_chg >= HD, "R5 setup", cyc - last_chg, HD);
            end
            if (!ser_clk && prev_clk) begin
                chk(hi_cnt == HD, "R5 high width", hi_cnt, HD);
                hi_cnt = 0;
            end
        end
        prev_clk = ser_clk;
        prev_dat = ser_dat;
    end

    task automatic do_rd(input logic [7:0] a);
        @(posedge clk); #1; host_addr = a; host_rd = 1;
        @(posedge clk); #1; host_rd = 0;
        if (!m_conv && !m_gain) begin
            if (a == 8'h38) begin m_conv = 1; m_err = 0; end
            else if (a == 8'h2C) begin m_gain = 1; m_err = 0; end
        end else if (a == 8'h28) m_pend = 1;
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1; host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk); #1; host_wr = 0;
        if (a == 8'h2C && !m_conv && !m_gain) m_err = 1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // chained = 1: one write per bit period, landing in the last high cycle
    task automatic send_word(input logic [31:0] w, input int n, input bit chained);
        for (int i = n - 1; i >= 0; i--) begin
            if (!chained) wait_idle();
            do_wr(8'h2C, {w[i], 7'h55});
            if (chained && i > 0) repeat (2 * HD - 2) @(posedge clk);
        end
        wait_idle();
    endtask

    task automatic chk_frame(input logic [31:0] w, input int n, input string tag);
        chk(cap.size() == n, tag, cap.size(), n);
        if (cap.size() == n)
            for (int i = 0; i < n; i++) chk(cap[i] == w[n-1-i], tag, cap[i], w[n-1-i]);
        cap.delete();
    endtask

    task automatic close_and_wait();
        do_rd(8'h28);
        wait_idle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] gw;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({sel_conv, sel_gain, ser_clk, ser_dat, busy, err} == 6'b0, "R1 reset",
            {sel_conv, sel_gain, ser_clk, ser_dat, busy, err}, 0);
        @(posedge clk); #1; rst_n = 1;

        // R2, R6: paced 16-bit left-level command
        do_rd(8'h38);
        @(negedge clk); chk(sel_conv, "R2 open conv", sel_conv, 1);
        cap.delete();
        send_word(32'h0000_A65A, 16, 0);
        chk_frame(32'h0000_A65A, 16, "R6 conv frame paced");
        close_and_wait();
        chk(!sel_conv, "R4 closed", sel_conv, 0);

        // R8, R6: chained right-level command
        do_rd(8'h38);
        cap.delete();
        send_word(32'h0000_A7C3, 16, 1);
        chk_frame(32'h0000_A7C3, 16, "R8 conv frame chained");
        close_and_wait();

        // R2, R6: 32-bit gain word {mic, mic, right, left}
        gw = {8'h3C, 8'h3C, 8'h81, 8'h07};
        do_rd(8'h2C);
        @(negedge clk); chk(sel_gain, "R2 open gain", sel_gain, 1);
        cap.delete();
        send_word(gw, 32, 1);
        chk_frame(gw, 32, "R6 gain frame");
        close_and_wait();

        // R3: open while already open
        do_rd(8'h38);
        do_rd(8'h2C);
        @(negedge clk);
        chk(sel_conv && !sel_gain, "R3 open ignored", {sel_conv, sel_gain}, 2);
        close_and_wait();

        // R9: write with no select
        cap.delete();
        do_wr(8'h2C, 8'h80);
        @(negedge clk); chk(err, "R9 err set", err, 1);
        repeat (4 * HD) @(negedge clk);
        chk(cap.size() == 0 && !busy, "R9 no pulse", cap.size(), 0);
        do_rd(8'h38);
        @(negedge clk); chk(!err, "R9 err cleared by open", err, 0);

        // R10: other offsets have no effect
        cap.delete();
        do_wr(8'h30, 8'hFF);
        do_wr(8'h24, 8'h80);
        do_rd(8'h34);
        do_rd(8'h20);
        repeat (4 * HD) @(negedge clk);
        chk(cap.size() == 0, "R10 no pulse", cap.size(), 0);
        chk(!busy && !err && sel_conv, "R10 state kept", {busy, err, sel_conv}, 1);

        // R8: three back-to-back writes, third discarded
        cap.delete();
        @(posedge clk); #1; host_addr = 8'h2C; host_wdata = 8'h80; host_wr = 1;
        @(posedge clk); #1; host_wdata = 8'h00;
        @(posedge clk); #1; host_wdata = 8'h80;
        @(posedge clk); #1; host_wr = 0; m_err = 1;
        @(negedge clk); chk(err, "R8 overflow err", err, 1);
        wait_idle();
        chk_frame(32'h2, 2, "R8 held bit sent");
        close_and_wait();

        // R4, R7: close while busy is deferred
        do_rd(8'h2C);
        cap.delete();
        do_wr(8'h2C, 8'hFF);
        @(negedge clk); chk(busy, "R7 busy after write", busy, 1);
        do_rd(8'h28);
        @(negedge clk);
        chk(sel_gain && busy, "R4 release deferred", {sel_gain, busy}, 3);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(!sel_gain && !ser_clk, "R4 released after idle", sel_gain, 0);
        chk_frame(32'h1, 1, "R5 single pulse");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule